// File: doc/BRIEF.md
# Character LCD Bus Controller

This block drives an 8-bit parallel bus to a character display module. The bus has a register-select line, a read/write line, an enable strobe and eight data lines. The data lines are bidirectional: the controller drives them through an output enable and releases them whenever it reads from the module. A small host interface hands the block one byte at a time, and each byte carries a flag that marks it as a command or as character data.

Every byte the block sends is gated by a status read. The controller reads the module's busy bit on data line 7, and repeats that read until the bit reads zero. Only then does it perform the write. After reset, the block sends a fixed four-command power-up sequence on its own, and it does not accept host bytes until that sequence has finished.

The strobe high time and the setup and hold times around it are given in nanoseconds. They are converted to clock cycles from the clock period, and each value is rounded up.

Top module: `lcd_bus_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the strobe is low, the data output enable is low and `host_ready` is low.
- R2: After reset the block writes four commands (select line 0): 0x38, 0x0E, 0x01 and 0x06, in that order. No host byte is written before them, and `host_ready` stays low until the fourth write completes.
- R3: Each strobe pulse stays high for at least 450 ns, which is at least 113 cycles at a 4 ns clock. Select, read/write and the driven data do not change while the strobe is high.
- R4: A status read has select at 0, read/write at 1 and the output enable at 0. Data line 7 is sampled while the strobe is high.
- R5: Every write is preceded by at least one status read. Reads repeat while data line 7 reads 1. No write takes place while the module reports busy.
- R6: A write has read/write at 0 and the output enable at 1. The data lines carry the requested byte. Select equals the data flag: 1 for character data, 0 for a command. The module latches the write on the falling edge of the strobe.
- R7: `host_ready` is high only after initialisation, while the bus is idle. A byte is taken in any cycle where `host_req` and `host_ready` are both high. `host_ready` is low in the next cycle and stays low until that byte's write is complete.
- R8: A request made while `host_ready` is low is ignored and produces no bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_req | input | 1 | Host offers a byte |
| host_is_data | input | 1 | 1 = character data, 0 = command |
| host_byte | input | 8 | Byte to write |
| host_ready | output | 1 | Block can take a byte this cycle |
| lcd_rs | output | 1 | Register select |
| lcd_rw | output | 1 | 1 = read, 0 = write |
| lcd_en | output | 1 | Enable strobe |
| lcd_db_out | output | 8 | Data driven onto the bus |
| lcd_db_oe | output | 1 | Output enable for the data lines |
| lcd_d7_in | input | 1 | Data line 7 as seen on the bus |

## Verification
The bench models the display module. The module reports busy for a random number of status reads after each write, from zero to three, so the single-read path and the repeated-read path are both covered. A controller that wrote after a read returning 1, or that sampled the busy bit outside the strobe, would write into a busy module and be reported. Requests held high during a write in progress must vanish without trace; a design that latched them would emit extra writes and break the expected byte order. The strobe width is measured in cycles against 450 ns, so a design that dropped one timing cycle would also be caught. A byte offered right at the end of initialisation checks that no host write can overtake the power-up commands.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RSET,
    PH_RHI,
    PH_RHLD,
    PH_WSET,
    PH_WHI,
    PH_WHLD
  } phase_t;

  localparam int INIT_LEN = 4;

  // power-up command list, sent as commands in index order
  function automatic logic [7:0] init_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h38;
      3'd1:    return 8'h0E;
      3'd2:    return 8'h01;
      default: return 8'h06;
    endcase
  endfunction

  // nanoseconds to whole clock cycles, rounded up, never zero
  function automatic int ns_to_cyc(input int ns, input int period_ps);
    int c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/lcd_bus_phy.sv
module lcd_bus_phy
  import lcd_bus_pkg::*;
#(
  parameter int SETUP_CYC = 15,
  parameter int HIGH_CYC  = 113,
  parameter int HOLD_CYC  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_rs,
  input  logic [7:0] start_byte,
  output logic       phy_idle,
  input  logic       d7_in,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  output logic [7:0] lcd_db_out,
  output logic       lcd_db_oe
);
  localparam int MAXC  = (SETUP_CYC > HIGH_CYC) ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                                                : ((HIGH_CYC > HOLD_CYC) ? HIGH_CYC : HOLD_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] SET_L = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HI_L  = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] HLD_L = CNT_W'(HOLD_CYC - 1);

  phase_t           st;
  logic [CNT_W-1:0] cnt;
  logic             rs_q;
  logic [7:0]       byte_q;
  logic             busy_q;

  wire tick      = (cnt == '0);
  wire rd_phase  = (st == PH_RSET) || (st == PH_RHI) || (st == PH_RHLD);
  wire wr_phase  = (st == PH_WSET) || (st == PH_WHI) || (st == PH_WHLD);
  // named event: the bus turns from a status read to a write
  wire wr_enter  = (st == PH_RHLD) && tick && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= PH_IDLE;
      cnt    <= '0;
      rs_q   <= 1'b0;
      byte_q <= 8'h00;
      busy_q <= 1'b0;
    end else begin
      case (st)
        PH_IDLE: if (start) begin
          rs_q   <= start_rs;
          byte_q <= start_byte;
          st     <= PH_RSET;
          cnt    <= SET_L;
        end
        PH_RSET: if (tick) begin st <= PH_RHI; cnt <= HI_L; end else cnt <= cnt - 1'b1;
        PH_RHI:  if (tick) begin
          busy_q <= d7_in;
          st     <= PH_RHLD;
          cnt    <= HLD_L;
        end else cnt <= cnt - 1'b1;
        PH_RHLD: if (tick) begin
          st  <= busy_q ? PH_RSET : PH_WSET;
          cnt <= SET_L;
        end else cnt <= cnt - 1'b1;
        PH_WSET: if (tick) begin st <= PH_WHI; cnt <= HI_L; end else cnt <= cnt - 1'b1;
        PH_WHI:  if (tick) begin st <= PH_WHLD; cnt <= HLD_L; end else cnt <= cnt - 1'b1;
        PH_WHLD: if (tick) st <= PH_IDLE; else cnt <= cnt - 1'b1;
        default: st <= PH_IDLE;
      endcase
    end
  end

  assign phy_idle   = (st == PH_IDLE);
  assign lcd_rw     = rd_phase;
  assign lcd_rs     = wr_phase & rs_q;
  assign lcd_en     = (st == PH_RHI) || (st == PH_WHI);
  assign lcd_db_oe  = wr_phase;
  assign lcd_db_out = wr_phase ? byte_q : 8'h00;

  // strobe length monitor for the width check
  logic [CNT_W:0] en_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_run <= '0;
    else if (lcd_en) en_run <= en_run + 1'b1;
    else             en_run <= '0;
  end

  p_en_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_en) |-> (en_run >= (CNT_W+1)'(HIGH_CYC)));

  p_en_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en && $past(lcd_en)) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_db_out)));

  p_read_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_rw |-> (!lcd_db_oe && !lcd_rs));

  p_write_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enter |=> (lcd_db_oe && !lcd_rw && $past(busy_q) == 1'b0));

  p_write_from_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_db_oe) |-> $past(st == PH_RHLD));

endmodule

// File: rtl/lcd_bus_front.sv
module lcd_bus_front
  import lcd_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_req,
  input  logic       host_is_data,
  input  logic [7:0] host_byte,
  output logic       host_ready,
  input  logic       phy_idle,
  output logic       start,
  output logic       start_rs,
  output logic [7:0] start_byte
);
  localparam logic [2:0] INIT_END = 3'(INIT_LEN);

  logic [2:0] init_idx;
  wire init_done  = (init_idx == INIT_END);
  wire init_issue = !init_done && phy_idle;
  wire host_take  = host_req && host_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          init_idx <= 3'd0;
    else if (init_issue) init_idx <= init_idx + 3'd1;
  end

  assign host_ready = init_done && phy_idle;
  assign start      = init_issue || host_take;
  assign start_rs   = init_done ? host_is_data : 1'b0;
  assign start_byte = init_done ? host_byte : init_byte(init_idx);

  p_ready_after_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> init_done);

  p_start_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> phy_idle);

  p_ready_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_take |=> !host_ready);

  p_init_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_issue |-> !start_rs);

endmodule

// File: rtl/lcd_bus_ctrl.sv
module lcd_bus_ctrl
  import lcd_bus_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int EN_HIGH_NS    = 450,
  parameter int SETUP_NS      = 60,
  parameter int HOLD_NS       = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_req,
  input  logic       host_is_data,
  input  logic [7:0] host_byte,
  output logic       host_ready,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  output logic [7:0] lcd_db_out,
  output logic       lcd_db_oe,
  input  logic       lcd_d7_in
);
  localparam int SETUP_CYC = ns_to_cyc(SETUP_NS,   CLK_PERIOD_PS);
  localparam int HIGH_CYC  = ns_to_cyc(EN_HIGH_NS, CLK_PERIOD_PS);
  localparam int HOLD_CYC  = ns_to_cyc(HOLD_NS,    CLK_PERIOD_PS);

  logic       phy_idle;
  logic       start;
  logic       start_rs;
  logic [7:0] start_byte;

  lcd_bus_front u_front (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_req     (host_req),
    .host_is_data (host_is_data),
    .host_byte    (host_byte),
    .host_ready   (host_ready),
    .phy_idle     (phy_idle),
    .start        (start),
    .start_rs     (start_rs),
    .start_byte   (start_byte)
  );

  lcd_bus_phy #(
    .SETUP_CYC (SETUP_CYC),
    .HIGH_CYC  (HIGH_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_phy (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_rs   (start_rs),
    .start_byte (start_byte),
    .phy_idle   (phy_idle),
    .d7_in      (lcd_d7_in),
    .lcd_rs     (lcd_rs),
    .lcd_rw     (lcd_rw),
    .lcd_en     (lcd_en),
    .lcd_db_out (lcd_db_out),
    .lcd_db_oe  (lcd_db_oe)
  );

endmodule

// File: tb/sim_lcd_bus_ctrl.sv
`timescale 1ns/1ps
module sim_lcd_bus_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_req = 1'b0;
  logic       host_is_data = 1'b0;
  logic [7:0] host_byte = 8'h00;
  logic       host_ready;
  logic       lcd_rs, lcd_rw, lcd_en, lcd_db_oe;
  logic [7:0] lcd_db_out;
  logic       lcd_d7_in;

  always #2 clk = ~clk;

  lcd_bus_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_is_data(host_is_data),
    .host_byte(host_byte), .host_ready(host_ready), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_en(lcd_en), .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .lcd_d7_in(lcd_d7_in)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // the strobe may not be shorter than 450 ns at a 4 ns period
  function automatic bit width_ok(input int cycles);
    return cycles * 4 >= 450;
  endfunction

  function automatic logic [7:0] cursor_at(input bit line2, input int col);
    return (line2 ? 8'hC0 : 8'h80) + 8'(col);
  endfunction

  // expected write list
  logic [8:0] exp_q [0:63];
  int exp_n = 0;
  int wr_n  = 0;

  // display-module model
  int  busy_left = 0;
  bit  saw_clear = 0;
  bit  prev_en = 0;
  int  en_len = 0;
  logic cap_rs, cap_rw;
  logic [7:0] cap_db;

  assign lcd_d7_in = (lcd_rw && lcd_en && !lcd_db_oe) ? (busy_left != 0) : 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (lcd_en && !prev_en) begin
        cap_rs = lcd_rs; cap_rw = lcd_rw; cap_db = lcd_db_out;
        en_len = 0;
      end
      if (lcd_en) begin
        en_len++;
        if (lcd_rs !== cap_rs || lcd_rw !== cap_rw || lcd_db_out !== cap_db)
          check(0, "R3 stable", {lcd_rs, lcd_rw, lcd_db_out}, {cap_rs, cap_rw, cap_db});
      end
      if (!lcd_en && prev_en) begin
        check(width_ok(en_len), "R3 width", en_len, 113);
        if (cap_rw) begin
          check(!cap_rs && !lcd_db_oe, "R4 read", {cap_rs, lcd_db_oe}, 0);
          if (busy_left > 0) busy_left--; else saw_clear = 1;
        end else begin
          check(busy_left == 0 && saw_clear, "R5 busy gate", busy_left, 0);
          check(lcd_db_oe, "R6 oe", lcd_db_oe, 1);
          if (wr_n < exp_n)
            check({cap_rs, cap_db} == exp_q[wr_n], "R6 write/R2 order", {cap_rs, cap_db}, exp_q[wr_n]);
          else
            check(0, "R8 extra write", {cap_rs, cap_db}, 0);
          wr_n++;
          busy_left = $urandom_range(0, 3);
          saw_clear = 0;
        end
      end
      prev_en = lcd_en;
    end
  end

  task automatic send(input bit is_data, input logic [7:0] b, input bit poke);
    do @(negedge clk); while (!host_ready);
    host_req = 1; host_is_data = is_data; host_byte = b;
    exp_q[exp_n] = {is_data, b}; exp_n++;
    @(negedge clk);
    host_req = 0;
    check(!host_ready, "R7 ready drop", host_ready, 0);
    if (poke) begin
      // R8: requests offered while busy must be dropped
      for (int k = 0; k < 3; k++) begin
        host_req = 1; host_is_data = 1; host_byte = 8'hEE;
        @(negedge clk);
        check(!host_ready, "R8 ready low", host_ready, 0);
      end
      host_req = 0;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    exp_q[0] = {1'b0, 8'h38}; exp_q[1] = {1'b0, 8'h0E};
    exp_q[2] = {1'b0, 8'h01}; exp_q[3] = {1'b0, 8'h06};
    exp_n = 4;
    saw_clear = 0;
    repeat (3) @(negedge clk);
    check(!lcd_en && !lcd_db_oe && !host_ready, "R1 reset", {lcd_en, lcd_db_oe, host_ready}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!host_ready, "R1 after reset", host_ready, 0);
    // R2: a request held from the start must wait for the power-up list
    host_req = 1; host_is_data = 1; host_byte = 8'h41;
    repeat (200) begin
      @(negedge clk);
      if (host_ready) break;
    end
    check(!host_ready, "R2 ready during init", host_ready, 0);
    host_req = 0;
    send(1'b0, cursor_at(1'b0, 3), 1'b0);
    check(wr_n == 4, "R2 init before host", wr_n, 4);
    send(1'b1, 8'h4E, 1'b1);
    send(1'b0, cursor_at(1'b1, 5), 1'b0);
    send(1'b1, 8'h4F, 1'b1);
    for (int i = 0; i < 12; i++)
      send(1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
    do @(negedge clk); while (!host_ready);
    repeat (20) @(negedge clk);
    check(wr_n == exp_n, "R8 write count", wr_n, exp_n);
    check(host_ready, "R7 idle ready", host_ready, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule